// File: doc/BRIEF.md
# Segmented Row-Column Thermometer Decoder

This block turns an 8-bit sample word into the switch controls of a segmented current-steering converter array. The six most significant bits select how many equal-weight unit cells of an 8×8 matrix are switched on; the two least significant bits are passed on as binary-weighted controls worth 2 and 1 LSB. Each unit cell is worth 4 LSB, so the total switched weight equals the input code.

The matrix is not driven by a flat 63-wire thermometer. A row decoder turns the upper three bits into a row thermometer. A column decoder turns the middle three bits into a column thermometer. Each cell then looks at its own row line, the next row's line and its column line. Cells fill row by row, and the last matrix position (row 7, column 7) is a dummy that is never enabled. A new word is taken when the sample-valid strobe is high. All cell enables, the binary controls and a count of active cells are updated together on one clock edge, one cycle after the word is presented.

Top module: `segThermDecoder`

## Requirements
- R1: One clock edge after a load, `binCtrl` equals bits [1:0] of the loaded code. Bit 1 is the 2-LSB control and bit 0 is the 1-LSB control.
- R2: After a load, every cell in a row whose index is below code bits [7:5] is enabled. Cell (row i, column j) is `cellEn[i*8+j]`.
- R3: After a load, in the row whose index equals code bits [7:5], exactly the cells whose column index is below code bits [4:2] are enabled.
- R4: After a load, every cell in a row whose index is above code bits [7:5] is disabled. Together with R2 and R3, the enabled cells form an unbroken run from index 0 in row-major order.
- R5: The dummy cell `cellEn[63]` (row 7, column 7) is 0 for every code.
- R6: `unitCount` equals the number of enabled cells, which is 8·code[7:5] + code[4:2].
- R7: The total weight 4·`unitCount` + 2·`binCtrl[1]` + `binCtrl[0]` equals the loaded code. Going from code n to code n+1 raises it by exactly one.
- R8: A word presented with `sampleValid` high reaches `cellEn`, `binCtrl` and `unitCount` together, at the next rising clock edge.
- R9: While `sampleValid` is low, `cellEn`, `binCtrl` and `unitCount` hold their values, whatever `code` does.
- R10: A synchronous reset clears `cellEn`, `binCtrl` and `unitCount` to 0 (the code-0 state). It takes precedence over `sampleValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Load strobe for `code` |
| code | input | 8 | Sample word: [7:5] row field, [4:2] column field, [1:0] binary part |
| cellEn | output | 64 | Registered unit-cell enables, index row*8+column |
| binCtrl | output | 2 | Registered binary-weighted controls |
| unitCount | output | 6 | Registered number of enabled unit cells |

## Verification
The bench builds the block with its default split of three row bits, three column bits and two binary bits. At that size all 256 codes can be swept one after another. Every row/column boundary, both ends of the range and every one-step transition are checked against a cell map computed from the row and column rules. Directed cases then vary the input while the strobe is low, and raise reset and the strobe in the same cycle, to cover the hold and precedence rules.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic clearAll;  // force the code-0 state
    logic loadWord;  // capture the decoded word
  } ctrlStrobes_t;
endpackage

// File: rtl/segdecThermo.sv
// Binary-to-thermometer decoder. INCLUSIVE picks the comparison:
// 1 -> line i is high when i <= field, 0 -> line i is high when i < field.
module segdecThermo #(
  parameter int FIELD_W   = 3,
  parameter bit INCLUSIVE = 1'b1,
  localparam int LINES    = 1 << FIELD_W,
  localparam int IDX_W    = FIELD_W + 1
) (
  input  logic [FIELD_W-1:0] field,
  output logic [LINES-1:0]   therm
);
  logic [IDX_W-1:0] fieldExt;
  assign fieldExt = {1'b0, field};

  for (genvar i = 0; i < LINES; i++) begin : gLine
    if (INCLUSIVE) begin : gIncl
      assign therm[i] = (IDX_W'(i) <= fieldExt);
    end else begin : gExcl
      assign therm[i] = (IDX_W'(i) < fieldExt);
    end
  end
endmodule

// File: rtl/segdecCell.sv
// Local selection logic of one unit cell.
//   rowHere=1, rowNext=1 -> on, whatever the column
//   rowHere=1, rowNext=0 -> follows the column line
//   rowHere=0            -> off (rowNext is also 0 for a thermometer)
module segdecCell (
  input  logic rowHere,
  input  logic rowNext,
  input  logic colOn,
  output logic cellOn
);
  always_comb begin
    unique case ({rowHere, rowNext})
      2'b11:   cellOn = 1'b1;
      2'b10:   cellOn = colOn;
      default: cellOn = 1'b0;
    endcase
  end
endmodule

// File: rtl/segdecCtrl.sv
module segdecCtrl
  import segdec_pkg::*;
(
  input  logic         rst,
  input  logic         sampleValid,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes          = '0;
    strobes.clearAll = rst;
    strobes.loadWord = sampleValid & ~rst;
  end
endmodule

// File: rtl/segdecDatapath.sv
module segdecDatapath
  import segdec_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int BIN_BITS = 2,
  localparam int ROWS    = 1 << ROW_BITS,
  localparam int COLS    = 1 << COL_BITS,
  localparam int CELLS   = ROWS * COLS,
  localparam int CODE_W  = ROW_BITS + COL_BITS + BIN_BITS,
  localparam int CNT_W   = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  ctrlStrobes_t      strobes,
  input  logic [CODE_W-1:0] code,
  output logic [CELLS-1:0]  cellEn,
  output logic [BIN_BITS-1:0] binCtrl,
  output logic [CNT_W-1:0]  unitCount
);
  logic [ROW_BITS-1:0] rowField;
  logic [COL_BITS-1:0] colField;
  logic [BIN_BITS-1:0] binField;

  assign binField = code[BIN_BITS-1:0];
  assign colField = code[BIN_BITS +: COL_BITS];
  assign rowField = code[BIN_BITS+COL_BITS +: ROW_BITS];

  logic [ROWS-1:0] rowTherm;
  logic [ROWS:0]   rowLine;   // one extra line above the top row, tied low
  logic [COLS-1:0] colLine;

  segdecThermo #(.FIELD_W(ROW_BITS), .INCLUSIVE(1'b1)) uRowDec (
    .field (rowField),
    .therm (rowTherm)
  );

  segdecThermo #(.FIELD_W(COL_BITS), .INCLUSIVE(1'b0)) uColDec (
    .field (colField),
    .therm (colLine)
  );

  assign rowLine = {1'b0, rowTherm};

  logic [CELLS-1:0] cellNext;

  for (genvar r = 0; r < ROWS; r++) begin : gRow
    for (genvar c = 0; c < COLS; c++) begin : gCol
      segdecCell uCell (
        .rowHere (rowLine[r]),
        .rowNext (rowLine[r+1]),
        .colOn   (colLine[c]),
        .cellOn  (cellNext[r*COLS+c])
      );
    end
  end

  logic [CNT_W-1:0] countNext;
  always_comb begin
    countNext = '0;
    for (int k = 0; k < CELLS; k++) begin
      countNext = countNext + CNT_W'(cellNext[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clearAll) begin
      cellEn    <= '0;
      binCtrl   <= '0;
      unitCount <= '0;
    end else if (strobes.loadWord) begin
      cellEn    <= cellNext;
      binCtrl   <= binField;
      unitCount <= countNext;
    end
  end
endmodule

// File: rtl/segThermDecoder.sv
module segThermDecoder
  import segdec_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int BIN_BITS = 2,
  localparam int CELLS   = (1 << ROW_BITS) * (1 << COL_BITS),
  localparam int CODE_W  = ROW_BITS + COL_BITS + BIN_BITS,
  localparam int CNT_W   = ROW_BITS + COL_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleValid,
  input  logic [CODE_W-1:0]   code,
  output logic [CELLS-1:0]    cellEn,
  output logic [BIN_BITS-1:0] binCtrl,
  output logic [CNT_W-1:0]    unitCount
);
  ctrlStrobes_t strobes;

  segdecCtrl uCtrl (
    .rst         (rst),
    .sampleValid (sampleValid),
    .strobes     (strobes)
  );

  segdecDatapath #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .BIN_BITS (BIN_BITS)
  ) uPath (
    .clk       (clk),
    .strobes   (strobes),
    .code      (code),
    .cellEn    (cellEn),
    .binCtrl   (binCtrl),
    .unitCount (unitCount)
  );
endmodule

// File: rtl/segdecChecker.sv
module segdecChecker #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int BIN_BITS = 2,
  localparam int CELLS   = (1 << ROW_BITS) * (1 << COL_BITS),
  localparam int CODE_W  = ROW_BITS + COL_BITS + BIN_BITS,
  localparam int CNT_W   = ROW_BITS + COL_BITS
) (
  input logic                clk,
  input logic                rst,
  input logic                sampleValid,
  input logic [CODE_W-1:0]   code,
  input logic [CELLS-1:0]    cellEn,
  input logic [BIN_BITS-1:0] binCtrl,
  input logic [CNT_W-1:0]    unitCount
);
  logic [CELLS:0] prefixMask;
  assign prefixMask = ({{CELLS{1'b0}}, 1'b1} << unitCount) - 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cellEn == '0 && binCtrl == '0 && unitCount == '0));  // R10

  AST_BIN_PASS: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> binCtrl == $past(code[BIN_BITS-1:0]));  // R1

  AST_COUNT_FOLLOWS_CODE: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> unitCount == $past(code[CODE_W-1:BIN_BITS]));  // R6

  AST_RUN_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    cellEn == prefixMask[CELLS-1:0]);  // R4

  AST_DUMMY_OFF: assert property (@(posedge clk) disable iff (rst)
    !cellEn[CELLS-1]);  // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> ($stable(cellEn) && $stable(binCtrl) && $stable(unitCount)));  // R9
endmodule

bind segThermDecoder segdecChecker #(
  .ROW_BITS (ROW_BITS),
  .COL_BITS (COL_BITS),
  .BIN_BITS (BIN_BITS)
) uChk (
  .clk         (clk),
  .rst         (rst),
  .sampleValid (sampleValid),
  .code        (code),
  .cellEn      (cellEn),
  .binCtrl     (binCtrl),
  .unitCount   (unitCount)
);

// File: tb/sim_segThermDecoder.sv
`timescale 1ns/1ps
module sim_segThermDecoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sampleValid = 1'b0;
  logic [7:0]  code = '0;
  logic [63:0] cellEn;
  logic [1:0]  binCtrl;
  logic [5:0]  unitCount;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  segThermDecoder u0 (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .code(code),
    .cellEn(cellEn), .binCtrl(binCtrl), .unitCount(unitCount)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected cell map from the row/column rules (R2, R3, R4, R5)
  function automatic logic [63:0] expectMap(input logic [7:0] w);
    logic [63:0] m = '0;
    int r = int'(w[7:5]);
    int c = int'(w[4:2]);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        m[i*8+j] = (i < r) || (i == r && j < c);
    return m;
  endfunction

  function automatic int weightNow();
    return 4 * int'(unitCount) + 2 * int'(binCtrl[1]) + int'(binCtrl[0]);
  endfunction

  task automatic loadCode(input logic [7:0] w);
    @(negedge clk);
    code = w;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(cellEn == '0, "R10", "cellEn after reset", cellEn, 0);
    check(binCtrl == '0, "R10", "binCtrl after reset", binCtrl, 0);
    check(unitCount == '0, "R10", "unitCount after reset", unitCount, 0);
    rst = 1'b0;
  endtask

  task automatic testSweep();
    int prevW = -1;
    for (int n = 0; n < 256; n++) begin
      logic [7:0] w = 8'(n);
      logic [63:0] em = expectMap(w);
      loadCode(w);
      check(cellEn == em, "R2/R3/R4", $sformatf("cell map code %0d", n), cellEn, em);
      check(cellEn[63] == 1'b0, "R5", $sformatf("dummy code %0d", n), cellEn[63], 0);
      check(binCtrl == w[1:0], "R1", $sformatf("binCtrl code %0d", n), binCtrl, w[1:0]);
      check(int'(unitCount) == 8 * int'(w[7:5]) + int'(w[4:2]), "R6",
            $sformatf("count code %0d", n), unitCount, 8 * int'(w[7:5]) + int'(w[4:2]));
      check(weightNow() == n, "R7", $sformatf("weight code %0d", n), weightNow(), n);
      if (prevW >= 0)
        check(weightNow() - prevW == 1, "R7", $sformatf("step into code %0d", n),
              weightNow() - prevW, 1);
      prevW = weightNow();
    end
  endtask

  task automatic testLatency();
    loadCode(8'h00);
    @(negedge clk);
    code = 8'hB6;
    sampleValid = 1'b1;
    @(posedge clk);
    #1;
    // r8_: all outputs move on the same edge that samples the strobe
    check(cellEn == expectMap(8'hB6), "R8", "cellEn right after edge", cellEn, expectMap(8'hB6));
    check(binCtrl == 2'b10, "R8", "binCtrl right after edge", binCtrl, 2'b10);
    check(unitCount == 6'd45, "R8", "unitCount right after edge", unitCount, 45);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic testHold();
    loadCode(8'h5D);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      code = 8'(8'hFF - k * 37);
    end
    @(negedge clk);
    check(cellEn == expectMap(8'h5D), "R9", "cellEn held", cellEn, expectMap(8'h5D));
    check(binCtrl == 2'b01, "R9", "binCtrl held", binCtrl, 1);
    check(unitCount == 6'd23, "R9", "unitCount held", unitCount, 23);
  endtask

  task automatic testResetPriority();
    loadCode(8'hFF);
    check(unitCount == 6'd63, "R6", "full-scale count", unitCount, 63);
    check(cellEn[63] == 1'b0, "R5", "dummy at full scale", cellEn[63], 0);
    @(negedge clk);
    rst = 1'b1;
    sampleValid = 1'b1;
    code = 8'hAA;
    @(negedge clk);
    rst = 1'b0;
    sampleValid = 1'b0;
    check(cellEn == '0, "R10", "reset beats valid cellEn", cellEn, 0);
    check(binCtrl == '0, "R10", "reset beats valid binCtrl", binCtrl, 0);
    check(unitCount == '0, "R10", "reset beats valid count", unitCount, 0);
  endtask

  initial begin
    testReset();
    testSweep();
    testLatency();
    testHold();
    testResetPriority();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule